// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block collects every reset request in the chip and turns them into two active-low reset outputs. One resets only the processor core. The other resets the rest of the chip. Whenever the chip reset is active, the core reset is active as well. The requests come from five sources:

- a brown-out comparator, already resolved to a digital level and synchronous to the clock
- a watchdog time-out
- a processor lockup indication
- two self-clearing software control bits

The brown-out level has to stay active for a selectable number of consecutive cycles before it counts as a request. A lockup is ignored while the debug-mode input is high. Every request that is taken sets a sticky cause flag. Software clears these flags by writing 1 to them, and only power-on clears them otherwise. Each chip reset also copies a boot-select bit from the configuration input. Each reset output is held for a fixed minimum number of cycles and is released on a clock edge.

Top module: `reset_hub`

## Requirements
- R1: While `rst_ni` (power-on) is low, both reset outputs are low and the status reads 6'b000001 (power-on flag, bit 0). After `rst_ni` rises, both outputs stay low for exactly 16 rising edges and are high after the 16th.
- R2: The deglitch select `bod_sel_i` gives a required run length. A value of 0 means no wait. Any value s from 1 to 7 means 2^(s+1) consecutive cycles. A brown-out level held high for fewer cycles than this causes no reset and sets no flag.
- R3: A brown-out level held high for at least the selected run length asserts both reset outputs and sets status bit 4. The reset is requested on the edge that completes the run.
- R4: A watchdog time-out asserts both reset outputs and sets status bit 2.
- R5: A lockup asserts both reset outputs and sets status bit 3. While `dbg_mode_i` is high, a lockup is ignored: no reset and no flag.
- R6: Writing 1 to control bit 1 asserts only `core_rst_no` and sets status bit 5. `periph_rst_no` stays high.
- R7: Writing 1 to control bit 0 asserts both outputs and sets status bit 1. `periph_rst_no` low always implies `core_rst_no` low.
- R8: `boot_sel_o` is loaded from `cfg_boot_i` while the chip reset is active, including after power-on. At all other times, including during a core-only reset, it holds its value.
- R9: A request on one edge keeps its output low for exactly 16 cycles after that edge. The output is then released on a rising clock edge.
- R10: A control bit written to 1 reads back as 1 on `ctrl_o` for one cycle. It then clears itself as its reset is issued.
- R11: Writing 1 through `sts_clr_i` with `sts_clr_we_i` clears the matching status flags, and zeros leave flags unchanged. If a flag is set and cleared in the same cycle, the set wins. Flags survive every reset except power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| bod_i | input | 1 | Brown-out comparator level, active high, clock-synchronous |
| bod_sel_i | input | 3 | Deglitch run-length select |
| wdt_tmo_i | input | 1 | Watchdog time-out request |
| lockup_i | input | 1 | Processor lockup indication |
| dbg_mode_i | input | 1 | Debug mode, masks lockup |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 2 | Control write data: bit 0 chip reset, bit 1 core reset |
| ctrl_o | output | 2 | Control register readback |
| sts_clr_we_i | input | 1 | Status clear strobe |
| sts_clr_i | input | 6 | Write-1-to-clear mask for status flags |
| sts_o | output | 6 | Cause flags: 0 power-on, 1 sw chip, 2 watchdog, 3 lockup, 4 brown-out, 5 sw core |
| cfg_boot_i | input | 1 | Boot-select value from configuration word |
| boot_sel_o | output | 1 | Boot-select bit |
| core_rst_no | output | 1 | Core reset, active low |
| periph_rst_no | output | 1 | Chip (peripheral) reset, active low |

## Verification
The bench tests brown-out pulses one cycle shorter than the run length and exactly equal to it, at select values 1, 3 and 7 and with deglitching off. A counter that is off by one either resets on the short pulse or misses the exact-length pulse. A lockup is applied with debug mode high, to catch a mask that is missing. A core-only reset is checked to leave the peripheral output high and the boot-select bit unchanged. The bench counts the exact width of the stretched pulse and the power-on release. It also checks that cause flags survive a software chip reset and that a partial clear removes only the selected flag.

// File: rtl/reset_hub_pkg.sv
package reset_hub_pkg;
  localparam int STS_W      = 6;
  localparam int STS_POR    = 0;
  localparam int STS_SWCHIP = 1;
  localparam int STS_WDT    = 2;
  localparam int STS_LOCK   = 3;
  localparam int STS_BOD    = 4;
  localparam int STS_SWCORE = 5;

  localparam int CTL_W    = 2;
  localparam int CTL_CHIP = 0;
  localparam int CTL_CORE = 1;

  typedef struct packed {
    logic sw_core;
    logic bod;
    logic lock;
    logic wdt;
    logic sw_chip;
  } rst_req_t;

  function automatic logic [STS_W-1:0] req_to_sts(rst_req_t r);
    logic [STS_W-1:0] s;
    s             = '0;
    s[STS_SWCHIP] = r.sw_chip;
    s[STS_WDT]    = r.wdt;
    s[STS_LOCK]   = r.lock;
    s[STS_BOD]    = r.bod;
    s[STS_SWCORE] = r.sw_core;
    return s;
  endfunction
endpackage

// File: rtl/bod_deglitch.sv
module bod_deglitch #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bod_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             req_o
);
  localparam int CNT_W = (1 << SEL_W) + 1;

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] run_q;

  // sel 0: no wait, else 2^(sel+1) cycles
  always_comb begin
    if (sel_i == '0) limit = '0;
    else             limit = CNT_W'(1) << (int'(sel_i) + 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (!bod_i)        run_q <= '0;
    else if (run_q < limit) run_q <= run_q + CNT_W'(1);
  end

  assign req_o = bod_i && ((limit == '0) || (run_q >= limit - CNT_W'(1)));
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic act_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;

  // power-on starts a full stretch window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(CYCLES);
      act_q <= 1'b1;
    end else if (req_i) begin
      cnt_q <= CW'(CYCLES);
      act_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      act_q <= (cnt_q != CW'(1));
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/reset_status.sv
module reset_status #(
  parameter int W = 6,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] sts_o
);
  logic [W-1:0] sts_q;

  // set wins over clear; only power-on resets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= RST_VAL;
    else         sts_q <= (sts_q & ~(clr_we_i ? clr_i : '0)) | set_i;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/reset_hub.sv
module reset_hub
  import reset_hub_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int STRETCH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bod_i,
  input  logic [SEL_W-1:0] bod_sel_i,
  input  logic             wdt_tmo_i,
  input  logic             lockup_i,
  input  logic             dbg_mode_i,
  input  logic             ctrl_we_i,
  input  logic [CTL_W-1:0] ctrl_wdata_i,
  output logic [CTL_W-1:0] ctrl_o,
  input  logic             sts_clr_we_i,
  input  logic [STS_W-1:0] sts_clr_i,
  output logic [STS_W-1:0] sts_o,
  input  logic             cfg_boot_i,
  output logic             boot_sel_o,
  output logic             core_rst_no,
  output logic             periph_rst_no
);
  localparam logic [STS_W-1:0] STS_RST = STS_W'(1) << STS_POR;

  logic [CTL_W-1:0] ctrl_q;
  logic             bod_req;
  rst_req_t         req;
  logic             chip_req;
  logic             core_req;
  logic             chip_act;
  logic             core_act;
  logic             boot_q;

  // control bits live one cycle, cleared as the request is issued
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
    else                ctrl_q <= '0;
  end

  bod_deglitch #(.SEL_W(SEL_W)) u_dgl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bod_i  (bod_i),
    .sel_i  (bod_sel_i),
    .req_o  (bod_req)
  );

  always_comb begin
    req.sw_core = ctrl_q[CTL_CORE];
    req.sw_chip = ctrl_q[CTL_CHIP];
    req.bod     = bod_req;
    req.wdt     = wdt_tmo_i;
    req.lock    = lockup_i && !dbg_mode_i;
  end

  assign chip_req = req.sw_chip | req.bod | req.wdt | req.lock;
  assign core_req = chip_req | req.sw_core;

  logic [1:0] dom_req;
  logic [1:0] dom_act;
  assign dom_req = {chip_req, core_req};

  for (genvar d = 0; d < 2; d++) begin : g_dom
    rst_stretch #(.CYCLES(STRETCH)) u_str (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (dom_req[d]),
      .act_o  (dom_act[d])
    );
  end

  assign core_act = dom_act[0];
  assign chip_act = dom_act[1];

  reset_status #(.W(STS_W), .RST_VAL(STS_RST)) u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (req_to_sts(req)),
    .clr_we_i (sts_clr_we_i),
    .clr_i    (sts_clr_i),
    .sts_o    (sts_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       boot_q <= 1'b0;
    else if (chip_act) boot_q <= cfg_boot_i;
  end

  assign ctrl_o        = ctrl_q;
  assign boot_sel_o    = boot_q;
  assign core_rst_no   = ~core_act;
  assign periph_rst_no = ~chip_act;
endmodule

// File: rtl/reset_hub_chk.sv
module reset_hub_chk #(
  parameter int STRETCH = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bod_i,
  input logic       wdt_tmo_i,
  input logic       lockup_i,
  input logic       dbg_mode_i,
  input logic [1:0] ctrl_o,
  input logic       sts_clr_we_i,
  input logic [5:0] sts_o,
  input logic       boot_sel_o,
  input logic       core_rst_no,
  input logic       periph_rst_no
);
  logic [5:0] low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            low_cnt <= '0;
    else if (!core_rst_no)  low_cnt <= (low_cnt == 6'h3f) ? low_cnt : low_cnt + 6'd1;
    else                    low_cnt <= '0;
  end

  p_stretch_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_no) |-> (int'(low_cnt) >= STRETCH));

  p_chip_has_core_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !periph_rst_no |-> !core_rst_no);

  p_wdt_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_tmo_i |=> sts_o[2]);

  p_lock_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[3]) |-> $past(lockup_i && !dbg_mode_i));

  p_bod_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o[4]) |-> $past(bod_i));

  p_sw_core_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[1] |=> !core_rst_no);

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_clr_we_i |=> ((sts_o & $past(sts_o)) == $past(sts_o)));

  p_boot_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(boot_sel_o) |-> $past(!periph_rst_no));
endmodule

bind reset_hub reset_hub_chk #(.STRETCH(STRETCH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bod_i         (bod_i),
  .wdt_tmo_i     (wdt_tmo_i),
  .lockup_i      (lockup_i),
  .dbg_mode_i    (dbg_mode_i),
  .ctrl_o        (ctrl_o),
  .sts_clr_we_i  (sts_clr_we_i),
  .sts_o         (sts_o),
  .boot_sel_o    (boot_sel_o),
  .core_rst_no   (core_rst_no),
  .periph_rst_no (periph_rst_no)
);

// File: tb/reset_hub_bench.sv
`timescale 1ns/1ps
module reset_hub_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bod_i = 1'b0;
  logic [2:0] bod_sel_i = 3'd0;
  logic       wdt_tmo_i = 1'b0;
  logic       lockup_i = 1'b0;
  logic       dbg_mode_i = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [1:0] ctrl_wdata_i = 2'd0;
  logic [1:0] ctrl_o;
  logic       sts_clr_we_i = 1'b0;
  logic [5:0] sts_clr_i = 6'd0;
  logic [5:0] sts_o;
  logic       cfg_boot_i = 1'b1;
  logic       boot_sel_o;
  logic       core_rst_no;
  logic       periph_rst_no;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk_i = ~clk_i;

  reset_hub u_reset_hub (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_sts(logic [5:0] m);
    sts_clr_we_i = 1'b1; sts_clr_i = m;
    @(negedge clk_i);
    sts_clr_we_i = 1'b0; sts_clr_i = 6'd0;
  endtask

  task automatic sw_write(logic [1:0] d);
    ctrl_we_i = 1'b1; ctrl_wdata_i = d;
    @(negedge clk_i);
    ctrl_we_i = 1'b0; ctrl_wdata_i = 2'd0;
  endtask

  // kind(3) sel(3) len(9) core(1) periph(1) sts(6)
  // kinds: 0 bod, 1 wdt, 2 lockup, 3 lockup+debug, 4 sw core, 5 sw chip
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {3'd0, 3'd1, 9'd3,   1'b0, 1'b0, 6'h00},  // R2
    {3'd0, 3'd1, 9'd4,   1'b1, 1'b1, 6'h10},  // R3
    {3'd0, 3'd0, 9'd1,   1'b1, 1'b1, 6'h10},  // R3 no deglitch
    {3'd0, 3'd3, 9'd15,  1'b0, 1'b0, 6'h00},  // R2
    {3'd0, 3'd3, 9'd16,  1'b1, 1'b1, 6'h10},  // R3
    {3'd0, 3'd7, 9'd255, 1'b0, 1'b0, 6'h00},  // R2
    {3'd0, 3'd7, 9'd256, 1'b1, 1'b1, 6'h10},  // R3
    {3'd1, 3'd0, 9'd1,   1'b1, 1'b1, 6'h04},  // R4
    {3'd2, 3'd0, 9'd1,   1'b1, 1'b1, 6'h08},  // R5
    {3'd3, 3'd0, 9'd3,   1'b0, 1'b0, 6'h00},  // R5 masked
    {3'd4, 3'd0, 9'd1,   1'b1, 1'b0, 6'h20},  // R6
    {3'd5, 3'd0, 9'd1,   1'b1, 1'b1, 6'h02}   // R7
  };

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int lows;
    // R1 power-on state
    repeat (3) @(negedge clk_i);
    chk("R1 core in por", core_rst_no, 0);
    chk("R1 periph in por", periph_rst_no, 0);
    chk("R1 status in por", sts_o, 6'h01);
    rst_ni = 1'b1;
    repeat (15) @(negedge clk_i);
    chk("R1 still held after 15", {core_rst_no, periph_rst_no}, 2'b00);
    @(negedge clk_i);
    chk("R1 released after 16", {core_rst_no, periph_rst_no}, 2'b11);
    chk("R8 boot loaded at por", boot_sel_o, 1);

    // R8 hold outside chip reset, core reset does not reload
    cfg_boot_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R8 boot holds idle", boot_sel_o, 1);
    sw_write(2'b10);
    chk("R10 ctrl readback", ctrl_o, 2'b10);
    @(negedge clk_i);
    chk("R10 ctrl self-clear", ctrl_o, 2'b00);
    chk("R6 periph stays high", periph_rst_no, 1);
    repeat (20) @(negedge clk_i);
    chk("R8 boot holds on core reset", boot_sel_o, 1);
    sw_write(2'b01);
    repeat (20) @(negedge clk_i);
    chk("R8 boot reload on chip reset", boot_sel_o, 0);
    cfg_boot_i = 1'b1;
    sw_write(2'b01);
    repeat (20) @(negedge clk_i);
    chk("R8 boot reload to one", boot_sel_o, 1);

    // R9 exact pulse width from a single-cycle watchdog request
    clr_sts(6'h3f);
    wdt_tmo_i = 1'b1;
    @(negedge clk_i);
    wdt_tmo_i = 1'b0;
    lows = (periph_rst_no == 1'b0) ? 1 : 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (!periph_rst_no) lows++;
    end
    chk("R9 stretch width", lows, 16);

    // R11 status survives chip reset, partial clear
    sw_write(2'b01);
    repeat (20) @(negedge clk_i);
    chk("R11 flags survive chip reset", sts_o, 6'h06);
    clr_sts(6'h04);
    chk("R11 partial clear", sts_o, 6'h02);
    clr_sts(6'h00);
    chk("R11 zero mask no effect", sts_o, 6'h02);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0] kind;
      int len;
      logic seen_c, seen_p;
      kind = VEC[v][22:20];
      len  = int'(VEC[v][16:8]);
      clr_sts(6'h3f);
      bod_sel_i = VEC[v][19:17];
      seen_c = 1'b0; seen_p = 1'b0;
      case (kind)
        3'd0: bod_i = 1'b1;
        3'd1: wdt_tmo_i = 1'b1;
        3'd2: lockup_i = 1'b1;
        3'd3: begin lockup_i = 1'b1; dbg_mode_i = 1'b1; end
        3'd4: begin ctrl_we_i = 1'b1; ctrl_wdata_i = 2'b10; end
        default: begin ctrl_we_i = 1'b1; ctrl_wdata_i = 2'b01; end
      endcase
      for (int i = 0; i < len + 24; i++) begin
        @(negedge clk_i);
        if (!core_rst_no) seen_c = 1'b1;
        if (!periph_rst_no) seen_p = 1'b1;
        if (i + 1 == len) begin
          bod_i = 1'b0; wdt_tmo_i = 1'b0; lockup_i = 1'b0; dbg_mode_i = 1'b0;
          ctrl_we_i = 1'b0; ctrl_wdata_i = 2'b00;
        end
      end
      case (kind)
        3'd0: begin
          chk($sformatf("R2/R3 vec%0d core", v), seen_c, VEC[v][7]);
          chk($sformatf("R2/R3 vec%0d periph", v), seen_p, VEC[v][6]);
          chk($sformatf("R2/R3 vec%0d status", v), sts_o, VEC[v][5:0]);
        end
        3'd1: begin
          chk("R4 core", seen_c, VEC[v][7]);
          chk("R4 periph", seen_p, VEC[v][6]);
          chk("R4 status", sts_o, VEC[v][5:0]);
        end
        3'd2, 3'd3: begin
          chk($sformatf("R5 vec%0d core", v), seen_c, VEC[v][7]);
          chk($sformatf("R5 vec%0d periph", v), seen_p, VEC[v][6]);
          chk($sformatf("R5 vec%0d status", v), sts_o, VEC[v][5:0]);
        end
        3'd4: begin
          chk("R6 core", seen_c, VEC[v][7]);
          chk("R6 periph", seen_p, VEC[v][6]);
          chk("R6 status", sts_o, VEC[v][5:0]);
        end
        default: begin
          chk("R7 core", seen_c, VEC[v][7]);
          chk("R7 periph", seen_p, VEC[v][6]);
          chk("R7 status", sts_o, VEC[v][5:0]);
        end
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule